// File: doc/BRIEF.md
# Microwire serial EEPROM responder

This block stands in for a 64-word by 16-bit Microwire serial EEPROM that software drives by bit-banging a single control register. Each write to the register sets the serial clock, select and data-in levels. The block finds select and clock edges by comparing each write with the copy it latched on the previous write. It shifts a 9-bit command in on rising clock edges and moves an output bit cursor on falling edges. The serial data-out bit is returned combinationally on every register read.

A preload port writes words into the storage array. After reset the array holds a computed image, so a read sequence has known contents before any preload. Only the read command is acted on. Any other opcode leaves data-out idle.

Top module: `mw_eeprom_resp`

## Requirements
- R1: A register write latches only the serial clock (bit 0), select (bit 1), data-in (bit 2), request (bit 4) and write-enable field (bits 9:8). Every read echoes those latched bits, and all other bits read 0 except the status and data-out bits.
- R2: Every register read returns the grant bit (bit 5) and the present bit (bit 6) as 1.
- R3: A write with select low changes no serial state: the cursor, reading flag, bit count and shift value keep their values, so data-out is unchanged.
- R4: A write with select high that follows a write with select low clears the shift value, the bit count, the cursor and the reading flag before it handles any clock edge.
- R5: A select-high write whose clock bit equals the previous latched clock bit is not an edge and changes no serial state.
- R6: A falling clock edge (latched 1, written 0, select high) advances the output cursor by one. The cursor wraps modulo 1024.
- R7: A rising clock edge shifts data-in into the low end of the shift value and increments the bit count. When the count reaches 9 with no read active, bits 8:6 are the opcode and bits 5:0 the word address. The cursor becomes address*16-1, and reading is set only for opcode 3'b110.
- R8: Data-out (bit 3) reads 1 whenever no read is active, including after a non-read opcode.
- R9: While reading, data-out is bit 15-cursor[3:0] of word cursor[9:4]. Words therefore go out most significant bit first, and the word index wraps from 63 to 0.
- R10: After reset word i holds IMG_SEED ^ (i*0x0F1D) truncated to 16 bits. A preload write with ld_en replaces word ld_addr with ld_data.
- R11: After reset the latched bits are 0 and no read is active, so a read returns 0x68.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Register write value |
| rd_data | output | 32 | Register read value: latched bits, status bits, data-out |
| ld_en | input | 1 | Storage preload strobe |
| ld_addr | input | 6 | Storage preload word address |
| ld_data | input | 16 | Storage preload word |

## Verification
On every cycle the assertions check several per-write rules. They cover the echo of the latched bits and the freeze of serial state on select-low and no-edge writes. They also check the clearing of state on a select rise, the single-step cursor advance on a falling edge, and data-out idling high while no read is active. Whether the right word and bit come out is shown only by the bench's read scenarios. These cover the command decode, the address*16-1 cursor preset, wrap from word 63 to word 0, preload contents, and rejection of a non-read opcode.

// File: rtl/mw_eeprom_pkg.sv
package mw_eeprom_pkg;
  // Control register field positions
  localparam int F_SCK  = 0;
  localparam int F_SEL  = 1;
  localparam int F_SDI  = 2;
  localparam int F_SDO  = 3;
  localparam int F_REQ  = 4;
  localparam int F_GNT  = 5;
  localparam int F_PRES = 6;
  localparam int F_WEN0 = 8;
  localparam int F_WEN1 = 9;

  localparam logic [2:0] OPC_READ = 3'b110;

  // Reset image word for index idx
  function automatic logic [31:0] img_word(input int idx, input logic [31:0] seed);
    logic [31:0] prod;
    prod = 32'(idx) * 32'h0000_0F1D;
    return seed ^ prod;
  endfunction
endpackage

// File: rtl/mw_reg_latch.sv
module mw_reg_latch
  import mw_eeprom_pkg::*;
#(
  parameter int REG_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] ctl_q,
  output logic             act,
  output logic             sel_rise,
  output logic             sck_rise,
  output logic             sck_fall
);
  localparam logic [REG_W-1:0] KEEP_MASK =
    (REG_W'(1) << F_SCK) | (REG_W'(1) << F_SEL) | (REG_W'(1) << F_SDI) |
    (REG_W'(1) << F_REQ) | (REG_W'(1) << F_WEN0) | (REG_W'(1) << F_WEN1);

  logic [REG_W-1:0] ctl_d;
  logic             sck_chg;

  always_comb begin
    ctl_d    = wr_en ? (wr_data & KEEP_MASK) : ctl_q;
    act      = wr_en & wr_data[F_SEL];
    sel_rise = act & ~ctl_q[F_SEL];
    sck_chg  = wr_data[F_SCK] ^ ctl_q[F_SCK];
    sck_rise = act & sck_chg & wr_data[F_SCK];
    sck_fall = act & sck_chg & ~wr_data[F_SCK];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctl_q <= '0;
    else        ctl_q <= ctl_d;
  end
endmodule

// File: rtl/mw_serial_seq.sv
module mw_serial_seq
  import mw_eeprom_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int BIT_W  = 4,
  parameter int CNT_W  = 16,
  localparam int CUR_W    = ADDR_W + BIT_W,
  localparam int CMD_BITS = ADDR_W + 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                act,
  input  logic                sel_rise,
  input  logic                sck_rise,
  input  logic                sck_fall,
  input  logic                sdi,
  output logic [CUR_W-1:0]    cursor_q,
  output logic                reading_q,
  output logic [CNT_W-1:0]    cnt_q,
  output logic [CMD_BITS-1:0] shift_q
);
  logic [CUR_W-1:0]    cursor_b, cursor_d;
  logic                reading_b, reading_d;
  logic [CNT_W-1:0]    cnt_b, cnt_d;
  logic [CMD_BITS-1:0] shift_b, shift_d;

  always_comb begin
    // state after a possible select-rise clear
    cursor_b  = sel_rise ? '0   : cursor_q;
    reading_b = sel_rise ? 1'b0 : reading_q;
    cnt_b     = sel_rise ? '0   : cnt_q;
    shift_b   = sel_rise ? '0   : shift_q;

    cursor_d  = cursor_b;
    reading_d = reading_b;
    cnt_d     = cnt_b;
    shift_d   = shift_b;

    if (sck_fall) begin
      cursor_d = cursor_b + CUR_W'(1);
    end else if (sck_rise) begin
      shift_d = {shift_b[CMD_BITS-2:0], sdi};
      cnt_d   = cnt_b + CNT_W'(1);
      if (cnt_d == CNT_W'(CMD_BITS) && !reading_b) begin
        cursor_d  = CUR_W'({shift_d[ADDR_W-1:0], {BIT_W{1'b0}}}) - CUR_W'(1);
        reading_d = (shift_d[CMD_BITS-1:ADDR_W] == OPC_READ);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cursor_q  <= '0;
      reading_q <= 1'b0;
      cnt_q     <= '0;
      shift_q   <= '0;
    end else if (act) begin
      cursor_q  <= cursor_d;
      reading_q <= reading_d;
      cnt_q     <= cnt_d;
      shift_q   <= shift_d;
    end
  end
endmodule

// File: rtl/mw_word_store.sv
module mw_word_store
  import mw_eeprom_pkg::*;
#(
  parameter int          ADDR_W   = 6,
  parameter int          WORD_W   = 16,
  parameter logic [31:0] IMG_SEED = 32'h0000_A5C3,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_en,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [WORD_W-1:0] ld_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [WORD_W-1:0] rd_word
);
  logic [WORD_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) begin
        mem_q[i] <= WORD_W'(img_word(i, IMG_SEED));
      end
    end else if (ld_en) begin
      mem_q[ld_addr] <= ld_data;
    end
  end

  assign rd_word = mem_q[rd_addr];
endmodule

// File: rtl/mw_eeprom_resp.sv
module mw_eeprom_resp
  import mw_eeprom_pkg::*;
#(
  parameter int          ADDR_W   = 6,
  parameter int          WORD_W   = 16,
  parameter int          REG_W    = 32,
  parameter int          CNT_W    = 16,
  parameter logic [31:0] IMG_SEED = 32'h0000_A5C3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [REG_W-1:0]  wr_data,
  output logic [REG_W-1:0]  rd_data,
  input  logic              ld_en,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [WORD_W-1:0] ld_data
);
  localparam int BIT_W    = $clog2(WORD_W);
  localparam int CUR_W    = ADDR_W + BIT_W;
  localparam int CMD_BITS = ADDR_W + 3;
  localparam logic [BIT_W-1:0] TOP_BIT = BIT_W'(WORD_W - 1);

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_pipe_q;
  logic       rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  logic [REG_W-1:0]    ctl_q;
  logic                act, sel_rise, sck_rise, sck_fall;
  logic [CUR_W-1:0]    cursor_q;
  logic                reading_q;
  logic [CNT_W-1:0]    cnt_q;
  logic [CMD_BITS-1:0] shift_q;
  logic [WORD_W-1:0]   cur_word;
  logic                sdo;

  mw_reg_latch #(.REG_W(REG_W)) u_latch (
    .clk(clk), .rst_n(rst_sync_n), .wr_en(wr_en), .wr_data(wr_data),
    .ctl_q(ctl_q), .act(act), .sel_rise(sel_rise),
    .sck_rise(sck_rise), .sck_fall(sck_fall)
  );

  mw_serial_seq #(.ADDR_W(ADDR_W), .BIT_W(BIT_W), .CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst_n(rst_sync_n), .act(act), .sel_rise(sel_rise),
    .sck_rise(sck_rise), .sck_fall(sck_fall), .sdi(wr_data[F_SDI]),
    .cursor_q(cursor_q), .reading_q(reading_q), .cnt_q(cnt_q), .shift_q(shift_q)
  );

  mw_word_store #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .IMG_SEED(IMG_SEED)) u_store (
    .clk(clk), .rst_n(rst_sync_n), .ld_en(ld_en), .ld_addr(ld_addr),
    .ld_data(ld_data), .rd_addr(cursor_q[CUR_W-1:BIT_W]), .rd_word(cur_word)
  );

  always_comb begin
    sdo     = ~reading_q | cur_word[TOP_BIT - cursor_q[BIT_W-1:0]];
    rd_data = ctl_q;
    rd_data[F_GNT]  = 1'b1;
    rd_data[F_PRES] = 1'b1;
    rd_data[F_SDO]  = sdo;
  end
endmodule

// File: rtl/mw_eeprom_chk.sv
module mw_eeprom_chk
  import mw_eeprom_pkg::*;
#(
  parameter int REG_W = 32,
  parameter int CUR_W = 10,
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [REG_W-1:0] wr_data,
  input logic [REG_W-1:0] rd_data,
  input logic [REG_W-1:0] ctl_q,
  input logic [CUR_W-1:0] cursor_q,
  input logic             reading_q,
  input logic [CNT_W-1:0] cnt_q
);
  localparam logic [REG_W-1:0] ECHO_MASK =
    (REG_W'(1) << F_SCK) | (REG_W'(1) << F_SEL) | (REG_W'(1) << F_SDI) |
    (REG_W'(1) << F_REQ) | (REG_W'(1) << F_WEN0) | (REG_W'(1) << F_WEN1);

  // R1
  echo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (rd_data & ECHO_MASK) == ($past(wr_data) & ECHO_MASK));

  // R3
  sel_low_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_data[F_SEL]) |=>
      ($stable(cursor_q) && $stable(reading_q) && $stable(cnt_q)));

  // R4
  sel_rise_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[F_SEL] && !ctl_q[F_SEL] && (wr_data[F_SCK] == ctl_q[F_SCK])) |=>
      (cursor_q == '0 && !reading_q && cnt_q == '0));

  // R5
  no_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[F_SEL] && ctl_q[F_SEL] && (wr_data[F_SCK] == ctl_q[F_SCK])) |=>
      ($stable(cursor_q) && $stable(cnt_q) && $stable(reading_q)));

  // R6
  fall_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[F_SEL] && ctl_q[F_SEL] && ctl_q[F_SCK] && !wr_data[F_SCK]) |=>
      (cursor_q == $past(cursor_q) + CUR_W'(1)));

  // R8
  idle_dout_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !reading_q |-> rd_data[F_SDO]);
endmodule

bind mw_eeprom_resp mw_eeprom_chk #(.REG_W(REG_W), .CUR_W(CUR_W), .CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst_n(rst_sync_n), .wr_en(wr_en), .wr_data(wr_data),
  .rd_data(rd_data), .ctl_q(ctl_q), .cursor_q(cursor_q),
  .reading_q(reading_q), .cnt_q(cnt_q)
);

// File: tb/mw_eeprom_resp_tb_top.sv
module mw_eeprom_resp_tb_top;
  localparam logic [31:0] SCK  = 32'h001;
  localparam logic [31:0] SEL  = 32'h002;
  localparam logic [31:0] SDI  = 32'h004;
  localparam logic [31:0] SDO  = 32'h008;
  localparam logic [31:0] GNT  = 32'h020;
  localparam logic [31:0] PRES = 32'h040;
  localparam logic [31:0] KEEP = 32'h317;
  localparam logic [31:0] SEED = 32'h0000_A5C3;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [31:0] wr_data;
  logic [31:0] rd_data;
  logic        ld_en;
  logic [5:0]  ld_addr;
  logic [15:0] ld_data;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  logic [15:0] mem_m [64];
  logic [31:0] exp_q [$];
  string       tag_q [$];

  always #10 clk = ~clk;

  mw_eeprom_resp dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .ld_en(ld_en), .ld_addr(ld_addr), .ld_data(ld_data)
  );

  function automatic logic [31:0] rdv(input logic [31:0] lat, input logic d);
    return (lat & KEEP) | GNT | PRES | (d ? SDO : 32'h0);
  endfunction

  function automatic logic mbit(input int cur);
    int c;
    c = cur & 1023;
    return mem_m[c >> 4][15 - (c & 15)];
  endfunction

  // scoreboard monitor
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (rd_data !== e) begin
        errors++;
        $display("FAIL %s: rd_data %h expected %h", t, rd_data, e);
      end
    end
  end

  task automatic expect_rd(input logic [31:0] e, input string t);
    exp_q.push_back(e);
    tag_q.push_back(t);
    wait (exp_q.size() == 0);
  endtask

  task automatic wr(input logic [31:0] v);
    @(negedge clk);
    wr_en = 1'b1;
    wr_data = v;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic preload(input int a, input logic [15:0] d);
    @(negedge clk);
    ld_en = 1'b1; ld_addr = 6'(a); ld_data = d;
    @(negedge clk);
    ld_en = 1'b0;
    mem_m[a] = d;
  endtask

  task automatic send_cmd(input logic [2:0] op, input int a);
    logic [8:0] cmd;
    cmd = {op, 6'(a)};
    wr(32'h0);
    wr(SEL);
    for (int i = 8; i >= 0; i--) begin
      wr(SEL | (cmd[i] ? SDI : 32'h0));
      wr(SEL | SCK | (cmd[i] ? SDI : 32'h0));
    end
  endtask

  task automatic shift_out(input int a, input int n, input string t);
    for (int k = 0; k < n; k++) begin
      wr(SEL);
      expect_rd(rdv(SEL, mbit(a * 16 + k)), t);
      wr(SEL | SCK);
      expect_rd(rdv(SEL | SCK, mbit(a * 16 + k)), t);
    end
  endtask

  initial begin
    #(20ns * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 64; i++) mem_m[i] = 16'(SEED ^ (32'(i) * 32'h0F1D));
    rst_n = 1'b0; wr_en = 1'b0; wr_data = '0;
    ld_en = 1'b0; ld_addr = '0; ld_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R11 R2: reset state
    expect_rd(32'h68, "R11 reset value");
    expect_rd(rdv(32'h0, 1'b1), "R2 status bits");

    // R1: only kept bits latched
    wr(32'hFFFF_FFFF);
    expect_rd(rdv(32'hFFFF_FFFF, 1'b1), "R1 all ones");
    wr(32'h0000_0210);
    expect_rd(rdv(32'h210, 1'b1), "R1 partial");

    // R7 R9: read word 5, continue into word 6
    send_cmd(3'b110, 5);
    expect_rd(rdv(SEL | SCK | SDI, mbit(5 * 16 - 1)), "R7 cursor preset");
    shift_out(5, 20, "R9 R6 word 5");

    // R7: address 0 preset points at last word bit 0
    send_cmd(3'b110, 0);
    expect_rd(rdv(SEL | SCK, mbit(1023)), "R7 addr 0 preset");
    shift_out(0, 3, "R9 word 0");

    // R9: wrap from word 63 to word 0
    send_cmd(3'b110, 63);
    expect_rd(rdv(SEL | SCK | SDI, mbit(63 * 16 - 1)), "R7 addr 63 preset");
    shift_out(63, 20, "R9 wrap");

    // R3: select low writes leave the output bit alone
    wr(32'h0);
    expect_rd(rdv(32'h0, mbit(63 * 16 + 19)), "R3 select low");
    wr(SDI);
    expect_rd(rdv(SDI, mbit(63 * 16 + 19)), "R3 select low data");
    // R4: select rise aborts the read
    wr(SEL | SCK);
    expect_rd(rdv(SEL | SCK, 1'b1), "R4 select rise clears");

    // R8: non-read opcode keeps data-out idle
    send_cmd(3'b101, 7);
    expect_rd(rdv(SEL | SCK | SDI, 1'b1), "R8 other opcode");
    wr(SEL);
    expect_rd(rdv(SEL, 1'b1), "R8 after fall");
    wr(SEL | SCK);
    expect_rd(rdv(SEL | SCK, 1'b1), "R8 after rise");

    // R5: same clock level is not an edge
    send_cmd(3'b110, 9);
    expect_rd(rdv(SEL | SCK | SDI, mbit(9 * 16 - 1)), "R7 addr 9 preset");
    wr(SEL | SCK);
    expect_rd(rdv(SEL | SCK, mbit(9 * 16 - 1)), "R5 no edge");
    shift_out(9, 4, "R5 continue");

    // R10: preload then read back
    preload(12, 16'h3C5A);
    send_cmd(3'b110, 12);
    expect_rd(rdv(SEL | SCK, mbit(12 * 16 - 1)), "R10 preset");
    shift_out(12, 16, "R10 preload word");

    done = 1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule